// File: doc/BRIEF.md
# CAN Controller Configuration Register File

This block holds the software-visible configuration state of a CAN controller. It sits on a simple 32-bit word bus made of address, write data, write strobe and combinational read data, and it is reset synchronously. It covers the following state:

- the master control word and the status word derived from it;
- a fixed transmit-status word;
- the bit-timing word;
- the acceptance-filter configuration: a filter master word, mode, scale, FIFO-assignment and activation words, and a parameterised set of filter banks, each made of two words.

The block runs the initialization handshake. Software raises the init request in the control word. One edge later the status word shows the init acknowledge and drops the sleep acknowledge. The bit-timing word is visible and writable only while that acknowledge is high. Filter configuration words are locked unless the filter-init flag is set. A filter bank is also writable while its own activation bit is clear. The CAN bit engine, arbitration and error counting live elsewhere and only consume these values.

Top module: `can_cfg_regs`

## Requirements
- R1: After reset the block reads as follows:
  - control (0x000) reads 0x00010002;
  - status (0x004) reads 0x00000C02;
  - transmit status (0x008) reads 0x1C000000;
  - offsets 0x00C, 0x010, 0x014 and 0x018 read 0;
  - filter master (0x200) reads 0x2A1C0E01.
- R2: A control write with bit 0 (init request) set makes status read 0x00000C01 on the next cycle. Status bit 0 is the init acknowledge, bit 1 is the sleep acknowledge, and bits 11:10 always read 1.
- R3: A control write with bit 0 clear drops the init acknowledge on the next cycle. The sleep acknowledge then takes control bit 1 of that write, so 0x00010000 gives status 0x00000C00 and 0x00010002 gives 0x00000C02.
- R4: The bit-timing word (0x01C) reads 0 while the init acknowledge is 0. While it is 1 the word reads its stored value, which is 0x01230000 after reset.
- R5: A write to the bit-timing word is stored only while the init acknowledge is 1, and it reads back as written, including bit 30 (loopback enable). A write made in normal mode is dropped.
- R6: The filter mode (0x204), scale (0x20C) and FIFO-assignment (0x214) words take writes only while filter master bit 0 (filter-init flag) is 1. Writes made while the flag is 0 leave them unchanged. All three reset to 0.
- R7: The filter activation word (0x21C) holds one bit per bank in bits NUM_BANKS-1:0 and resets to 0. With 28 banks, bits 31:28 always read 0.
- R8: Filter bank k has two words, at 0x240+8k and 0x244+8k, which reset to 0. A write to either word is stored when the filter-init flag is 1 or when activation bit k is 0. Otherwise the write is dropped.
- R9: Unmapped or misaligned offsets read 0 and ignore writes. Transmit status and 0x00C to 0x018 are read-only.
- R10: The filter master word is freely writable and reads back as written. Its bit 0 is the filter-init flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (12) | Byte address of the accessed word |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |

## Verification
Every write is stored on the rising edge that samples its strobe. Derived results are visible one cycle after the write: the status acknowledges, the bit-timing visibility and the lock decisions that follow a change of the filter-init flag or of the activation bits. Reads are combinational, so a value is valid in the same cycle its address is presented. The bench drives every access on the falling edge and deasserts the strobe on the next falling edge. It then samples the read data a little after a falling edge, once the write edge has passed. Random phases mix filter-init, activation and bank writes, and a bench model built from the requirements predicts each read-back.

// File: rtl/can_cfg_pkg.sv
// Package: shared offsets and reset values of the CAN configuration register file.
// Assumes byte addresses with word-aligned accesses and a 12-bit offset space.
package can_cfg_pkg;
    localparam int          DW          = 32;
    localparam int          OFF_W       = 12;

    localparam logic [OFF_W-1:0] OFF_CTRL   = 12'h000;
    localparam logic [OFF_W-1:0] OFF_STAT   = 12'h004;
    localparam logic [OFF_W-1:0] OFF_TXST   = 12'h008;
    localparam logic [OFF_W-1:0] OFF_BTIM   = 12'h01C;
    localparam logic [OFF_W-1:0] OFF_FMAST  = 12'h200;
    localparam logic [OFF_W-1:0] OFF_FMODE  = 12'h204;
    localparam logic [OFF_W-1:0] OFF_FSCALE = 12'h20C;
    localparam logic [OFF_W-1:0] OFF_FFIFO  = 12'h214;
    localparam logic [OFF_W-1:0] OFF_FACT   = 12'h21C;
    localparam logic [OFF_W-1:0] OFF_BANK0  = 12'h240;

    localparam logic [DW-1:0] RST_CTRL  = 32'h0001_0002;
    localparam logic [DW-1:0] VAL_TXST  = 32'h1C00_0000;
    localparam logic [DW-1:0] RST_BTIM  = 32'h0123_0000;
    localparam logic [DW-1:0] RST_FMAST = 32'h2A1C_0E01;
endpackage

// File: rtl/can_mode_ctrl.sv
// Module: control word, init/sleep acknowledge and the bit-timing word.
// Assumes ctrl_we and btim_we are single-cycle strobes already decoded.
// The acknowledges follow the written control value on the same edge.
module can_mode_ctrl
    import can_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic          btim_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic          init_ack,
    output logic          sleep_ack,
    output logic [DW-1:0] btim_q
);
    // Control word plus handshake acknowledges; init request has priority over sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= RST_CTRL;
            init_ack  <= 1'b0;
            sleep_ack <= 1'b1;
        end else if (ctrl_we) begin
            ctrl_q    <= wdata;
            init_ack  <= wdata[0];
            sleep_ack <= wdata[1] & ~wdata[0];
        end
    end

    // Bit-timing word, writable only while initialization is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            btim_q <= RST_BTIM;
        else if (btim_we && init_ack)
            btim_q <= wdata;
    end
endmodule

// File: rtl/can_filt_glob.sv
// Module: filter master, mode, scale, FIFO-assignment and activation words.
// Assumes one-hot write strobes from the top decoder; bit 0 of the master word is the filter-init flag.
module can_filt_glob
    import can_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fmast_we,
    input  logic                 fmode_we,
    input  logic                 fscale_we,
    input  logic                 ffifo_we,
    input  logic                 fact_we,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        fmast_q,
    output logic [DW-1:0]        fmode_q,
    output logic [DW-1:0]        fscale_q,
    output logic [DW-1:0]        ffifo_q,
    output logic [NUM_BANKS-1:0] fact_q
);
    logic finit;
    assign finit = fmast_q[0];

    // Filter master word, always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fmast_q <= RST_FMAST;
        else if (fmast_we)
            fmast_q <= wdata;
    end

    // Mode, scale and FIFO-assignment words, locked unless filter-init is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmode_q  <= '0;
            fscale_q <= '0;
            ffifo_q  <= '0;
        end else if (finit) begin
            if (fmode_we)  fmode_q  <= wdata;
            if (fscale_we) fscale_q <= wdata;
            if (ffifo_we)  ffifo_q  <= wdata;
        end
    end

    // Activation bits, one per bank; upper bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fact_q <= '0;
        else if (fact_we)
            fact_q <= wdata[NUM_BANKS-1:0];
    end
endmodule

// File: rtl/can_filt_bank.sv
// Module: one filter bank of two 32-bit words.
// Assumes 'unlocked' is already the OR of filter-init and the inverted activation bit.
module can_filt_bank
    import can_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_lo,
    input  logic          we_hi,
    input  logic          unlocked,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] lo_q,
    output logic [DW-1:0] hi_q
);
    // Both bank words, written only while the bank is unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (unlocked) begin
            if (we_lo) lo_q <= wdata;
            if (we_hi) hi_q <= wdata;
        end
    end
endmodule

// File: rtl/can_cfg_regs.sv
// Module: top of the CAN configuration register file; decodes the word bus and muxes reads.
// Assumes byte addresses; misaligned or unmapped offsets read 0 and drop writes.
module can_cfg_regs
    import can_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 28,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data
);
    localparam int                BANK_IW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [ADDR_W-1:0] BANK_BASE = ADDR_W'(OFF_BANK0);
    localparam logic [ADDR_W-1:0] BANK_SPAN = ADDR_W'(NUM_BANKS * 8);

    logic [DW-1:0]        ctrl_q, btim_q;
    logic                 init_ack, sleep_ack;
    logic [DW-1:0]        fmast_q, fmode_q, fscale_q, ffifo_q;
    logic [NUM_BANKS-1:0] fact_q;
    logic                 finit;
    logic [DW-1:0]        bank_lo [NUM_BANKS];
    logic [DW-1:0]        bank_hi [NUM_BANKS];

    logic [ADDR_W-1:0]    rel;
    logic                 in_bank;
    logic [BANK_IW-1:0]   bidx;

    assign finit   = fmast_q[0];
    assign rel     = addr - BANK_BASE;
    assign in_bank = (addr >= BANK_BASE) && (rel < BANK_SPAN) && (rel[1:0] == 2'b00);
    assign bidx    = rel[BANK_IW+2:3];

    can_mode_ctrl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (wr_en && addr == ADDR_W'(OFF_CTRL)),
        .btim_we   (wr_en && addr == ADDR_W'(OFF_BTIM)),
        .wdata     (wr_data),
        .ctrl_q    (ctrl_q),
        .init_ack  (init_ack),
        .sleep_ack (sleep_ack),
        .btim_q    (btim_q)
    );

    can_filt_glob #(.NUM_BANKS(NUM_BANKS)) u_glob (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmast_we  (wr_en && addr == ADDR_W'(OFF_FMAST)),
        .fmode_we  (wr_en && addr == ADDR_W'(OFF_FMODE)),
        .fscale_we (wr_en && addr == ADDR_W'(OFF_FSCALE)),
        .ffifo_we  (wr_en && addr == ADDR_W'(OFF_FFIFO)),
        .fact_we   (wr_en && addr == ADDR_W'(OFF_FACT)),
        .wdata     (wr_data),
        .fmast_q   (fmast_q),
        .fmode_q   (fmode_q),
        .fscale_q  (fscale_q),
        .ffifo_q   (ffifo_q),
        .fact_q    (fact_q)
    );

    // One bank instance per filter bank, each with its own lock.
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic sel;
        assign sel = wr_en && in_bank && (bidx == BANK_IW'(k));
        can_filt_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_lo    (sel && !rel[2]),
            .we_hi    (sel &&  rel[2]),
            .unlocked (finit || !fact_q[k]),
            .wdata    (wr_data),
            .lo_q     (bank_lo[k]),
            .hi_q     (bank_hi[k])
        );
    end

    // Read mux; bit timing hidden outside init, unmapped offsets return 0.
    always_comb begin
        rd_data = '0;
        if (in_bank)
            rd_data = rel[2] ? bank_hi[bidx] : bank_lo[bidx];
        else if (addr == ADDR_W'(OFF_CTRL))   rd_data = ctrl_q;
        else if (addr == ADDR_W'(OFF_STAT))   rd_data = {20'h0, 2'b11, 8'h0, sleep_ack, init_ack};
        else if (addr == ADDR_W'(OFF_TXST))   rd_data = VAL_TXST;
        else if (addr == ADDR_W'(OFF_BTIM))   rd_data = init_ack ? btim_q : '0;
        else if (addr == ADDR_W'(OFF_FMAST))  rd_data = fmast_q;
        else if (addr == ADDR_W'(OFF_FMODE))  rd_data = fmode_q;
        else if (addr == ADDR_W'(OFF_FSCALE)) rd_data = fscale_q;
        else if (addr == ADDR_W'(OFF_FFIFO))  rd_data = ffifo_q;
        else if (addr == ADDR_W'(OFF_FACT))   rd_data = DW'(fact_q);
    end
endmodule

// File: rtl/can_cfg_regs_chk.sv
// Module: assertion checker bound to can_cfg_regs; observes ports and handshake state.
// Assumes the default offset map from can_cfg_pkg.
module can_cfg_regs_chk
    import can_cfg_pkg::*;
#(
    parameter int NUM_BANKS = 28,
    parameter int ADDR_W    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DW-1:0]     wr_data,
    input logic [DW-1:0]     rd_data,
    input logic              init_ack,
    input logic              finit,
    input logic [DW-1:0]     fmode_q
);
    // R2: init request acknowledged on the next edge.
    p_init_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_CTRL) && wr_data[0]) |=> init_ack);

    // R3: clearing the request drops the acknowledge on the next edge.
    p_init_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_CTRL) && !wr_data[0]) |=> !init_ack);

    // R4: bit timing reads zero outside initialization.
    p_btim_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFF_BTIM) && !init_ack) |-> (rd_data == '0));

    // R6: mode word stays put when written under the filter lock.
    p_fmode_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_FMODE) && !finit) |=> $stable(fmode_q));

    // R7: reserved activation bits read zero.
    p_fact_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFF_FACT)) |-> ((rd_data >> NUM_BANKS) == '0));

    // R9: a read-only hole reads zero.
    p_hole_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(12'h00C)) |-> (rd_data == '0));
endmodule

bind can_cfg_regs can_cfg_regs_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .init_ack (init_ack),
    .finit    (finit),
    .fmode_q  (fmode_q)
);

// File: tb/tb_can_cfg_regs.sv
// Bench: directed handshake and lock cases plus seeded random filter-bank traffic.
module tb_can_cfg_regs;
    localparam int NB = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_lo [NB];
    logic [31:0] m_hi [NB];
    logic [NB-1:0] m_act;
    bit          m_finit;

    can_cfg_regs #(.NUM_BANKS(NB), .ADDR_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    function automatic logic [11:0] bank_addr(input int k, input bit hi);
        return 12'h240 + 12'(k * 8) + (hi ? 12'h4 : 12'h0);
    endfunction

    function automatic bit bank_open(input int k);
        return m_finit || !m_act[k];
    endfunction

    initial begin
        for (int i = 0; i < 8000; i++) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int k = 0; k < NB; k++) begin m_lo[k] = '0; m_hi[k] = '0; end
        m_act = '0; m_finit = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 ctrl",  12'h000, 32'h0001_0002);
        chk("R1 stat",  12'h004, 32'h0000_0C02);
        chk("R1 txst",  12'h008, 32'h1C00_0000);
        chk("R1 0c",    12'h00C, 32'h0);
        chk("R1 10",    12'h010, 32'h0);
        chk("R1 14",    12'h014, 32'h0);
        chk("R1 18",    12'h018, 32'h0);
        chk("R1 fmast", 12'h200, 32'h2A1C_0E01);
        chk("R4 btim hidden at reset", 12'h01C, 32'h0);

        // R2 / R4 / R5 init handshake and bit timing
        wr(12'h000, 32'h0001_0001);
        chk("R2 stat init", 12'h004, 32'h0000_0C01);
        chk("R4 btim reset value", 12'h01C, 32'h0123_0000);
        wr(12'h01C, 32'h4123_0000);
        chk("R5 loopback readback", 12'h01C, 32'h4123_0000);
        wr(12'h000, 32'h0001_0003);
        chk("R2 init over sleep", 12'h004, 32'h0000_0C01);

        // R3 leave init; R5 write in normal mode dropped
        wr(12'h000, 32'h0001_0000);
        chk("R3 stat normal", 12'h004, 32'h0000_0C00);
        chk("R4 btim hidden", 12'h01C, 32'h0);
        wr(12'h01C, 32'h1234_5678);
        wr(12'h000, 32'h0001_0002);
        chk("R3 sleep ack", 12'h004, 32'h0000_0C02);
        wr(12'h000, 32'h0001_0001);
        chk("R5 normal write dropped", 12'h01C, 32'h4123_0000);

        // R6 / R10 filter configuration lock
        wr(12'h204, 32'hFF00_00FF);
        wr(12'h20C, 32'h0F0F_0F0F);
        wr(12'h214, 32'h1234_ABCD);
        chk("R6 mode open",  12'h204, 32'hFF00_00FF);
        chk("R6 scale open", 12'h20C, 32'h0F0F_0F0F);
        chk("R6 fifo open",  12'h214, 32'h1234_ABCD);
        wr(12'h200, 32'h2A1C_0E00); m_finit = 1'b0;
        chk("R10 fmast readback", 12'h200, 32'h2A1C_0E00);
        wr(12'h204, 32'h00FF_FF00);
        wr(12'h20C, 32'hF0F0_F0F0);
        wr(12'h214, 32'h0);
        chk("R6 mode locked",  12'h204, 32'hFF00_00FF);
        chk("R6 scale locked", 12'h20C, 32'h0F0F_0F0F);
        chk("R6 fifo locked",  12'h214, 32'h1234_ABCD);

        // R7 activation reserved bits
        wr(12'h21C, 32'hFFFF_FFFF); m_act = '1;
        chk("R7 reserved zero", 12'h21C, 32'h0FFF_FFFF);

        // R8 directed: bank locked by activation, another open
        wr(12'h21C, 32'h0000_0020); m_act = 28'h20;
        wr(bank_addr(5, 0), 32'hDEAD_BEEF);
        chk("R8 active bank locked", bank_addr(5, 0), 32'h0);
        wr(bank_addr(6, 1), 32'hCAFE_F00D); m_hi[6] = 32'hCAFE_F00D;
        chk("R8 inactive bank open", bank_addr(6, 1), 32'hCAFE_F00D);
        wr(12'h200, 32'h2A1C_0E01); m_finit = 1'b1;
        wr(bank_addr(5, 0), 32'hDEAD_BEEF); m_lo[5] = 32'hDEAD_BEEF;
        chk("R8 finit unlocks", bank_addr(5, 0), 32'hDEAD_BEEF);
        chk("R8 last bank reset", bank_addr(NB - 1, 1), 32'h0);

        // R9 unmapped, misaligned and read-only
        wr(12'h00C, 32'hFFFF_FFFF);
        chk("R9 ro hole", 12'h00C, 32'h0);
        wr(12'h008, 32'h0);
        chk("R9 txst ro", 12'h008, 32'h1C00_0000);
        wr(12'h3F0, 32'h5555_5555);
        chk("R9 unmapped", 12'h3F0, 32'h0);
        wr(12'h241, 32'h7777_7777);
        chk("R9 misaligned", 12'h241, 32'h0);
        chk("R9 bank0 untouched", bank_addr(0, 0), 32'h0);

        // R8 random traffic against the bench model
        for (int it = 0; it < 600; it++) begin
            int sel = $urandom_range(0, 9);
            int k   = $urandom_range(0, NB - 1);
            bit hi  = 1'($urandom_range(0, 1));
            logic [31:0] d = $urandom;
            if (sel == 0) begin
                m_finit = 1'(d[0]);
                wr(12'h200, d);
            end else if (sel == 1) begin
                m_act = d[NB-1:0];
                wr(12'h21C, d);
            end else begin
                if (bank_open(k)) begin
                    if (hi) m_hi[k] = d; else m_lo[k] = d;
                end
                wr(bank_addr(k, hi), d);
            end
            if (it % 4 == 3) begin
                int r = $urandom_range(0, NB - 1);
                chk("R8 random lo", bank_addr(r, 0), m_lo[r]);
                chk("R8 random hi", bank_addr(r, 1), m_hi[r]);
            end
        end
        chk("R7 random act", 12'h21C, 32'(m_act));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule